// File: doc/BRIEF.md
# IQ Envelope Playback Upconverter

This block plays a stored complex envelope out to an RF DAC. A host loads pairs of signed in-phase and quadrature samples into a two-bank on-chip memory through a simple write port. On a start pulse from the pulse sequencer, the block walks the memory from address 0 up to a programmed depth. It holds each entry for a programmed number of clock cycles. Each played pair is mixed with the cosine and sine words of an external, fixed-frequency oscillator that is shared with the receive path. The real part of the complex product is rounded, saturated and registered as one signed DAC word per clock.

The sequencer state machine has two states. ST_IDLE leaves the output at zero. ST_PLAY issues one memory read per cycle. The transitions are: IDLE→PLAY when start is seen with a non-zero depth; PLAY→PLAY while entries remain, with the hold counter either advancing or wrapping and the address stepping; PLAY→IDLE when the hold counter of the final address wraps, which tags the last sample; and PLAY→IDLE on stop, which aborts the pass. Each address has a bank bit, and a snapshot of these bits is taken at start. Host writes never land in the bank being played, so an edit made during a pass is seen on the next pass.

Top module: `iq_playback_upconv`

## Requirements
- R1: A write with wr_en high stores the pair (wr_i, wr_q) at wr_addr. A pass plays addresses 0, 1, 2 … in ascending order.
- R2: Each address is held for cfg_rate consecutive output cycles. A cfg_rate of 0 or 1 gives a new address on every clock.
- R3: A pass plays addresses 0 to cfg_depth−1 only. A cfg_depth above 2^AW plays the whole memory. A start with cfg_depth equal to 0 is ignored: no sample and no done.
- R4: Each output word is floor((I·cos − Q·sin + 2^14) / 2^15), clamped to the range −32768 to 32767 (16-bit two's complement).
- R5: Step k of a pass (k counted from 0) appears on dac_out with dac_valid high during the (k+4)-th cycle after the clock edge that accepts start. It uses the oscillator words present two cycles earlier.
- R6: In the cycle after the last sample of a complete pass, done is high for exactly one cycle, with dac_valid low and dac_out zero.
- R7: Whenever dac_valid is low, dac_out is zero.
- R8: Start clears the address and the hold counter. A start seen during a pass is ignored. cfg_rate and cfg_depth are captured at start, and later changes do not affect the running pass.
- R9: Stop during a pass ends it. Samples already issued still come out, no further sample is issued, and done does not pulse.
- R10: A write made during a pass, or in the same cycle as an accepted start, does not change the running pass. It is played from the next pass on.
- R11: After reset, dac_out is zero and dac_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock shared with the DAC |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Memory write strobe |
| wr_addr | input | AW | Memory write address |
| wr_i | input | SW | In-phase sample to store (signed) |
| wr_q | input | SW | Quadrature sample to store (signed) |
| cfg_rate | input | RW | Cycles each entry is held |
| cfg_depth | input | AW+1 | Number of entries played per pass |
| start | input | 1 | Begin a pass (sampled in idle only) |
| stop | input | 1 | Abort the running pass |
| nco_cos | input | CW | Oscillator cosine word (signed) |
| nco_sin | input | CW | Oscillator sine word (signed) |
| dac_out | output | OW | Registered DAC sample (signed) |
| dac_valid | output | 1 | High while a played sample is on dac_out |
| done | output | 1 | One-cycle pulse after a complete pass |

## Verification
The assertions check on every cycle that the output is zero whenever it is not valid, and that done is a lone pulse on a quiet output. They also check that a read address never reaches the captured depth, that start lands on address zero, that stop removes the issue strobe, and that dac_valid trails the issue strobe by three cycles. The exact mixed, rounded and saturated values, the hold length per address, and the depth clamp can only be shown by the bench's scenarios. The same holds for ignored depth-zero and mid-pass starts, and for writes that are deferred to the next pass. The bench compares each output word against a bench-side model of the memory and the oscillator history.

// File: rtl/iqpb_pkg.sv
package iqpb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } iqpb_state_e;

endpackage

// File: rtl/iqpb_bank_ram.sv
module iqpb_bank_ram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          snap,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [2*DEPTH];
    logic [DEPTH-1:0] newest_bank;
    logic [DEPTH-1:0] frozen_bank;
    logic             wr_bank;

    // Never write into the bank the current (or just-starting) pass reads.
    always_comb begin
        wr_bank = snap ? ~newest_bank[wr_addr] : ~frozen_bank[wr_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            newest_bank <= '0;
            frozen_bank <= '0;
        end else begin
            if (snap) begin
                frozen_bank <= newest_bank;
            end
            if (wr_en) begin
                newest_bank[wr_addr] <= wr_bank;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_bank, wr_addr}] <= wr_data;
        end
        rd_data <= mem[{frozen_bank[rd_addr], rd_addr}];
    end

endmodule

// File: rtl/iqpb_seq.sv
module iqpb_seq
    import iqpb_pkg::*;
#(
    parameter int AW = 8,
    parameter int RW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic [RW-1:0] cfg_rate,
    input  logic [AW:0]   cfg_depth,
    output logic          start_acc,
    output logic          issue_vld,
    output logic          issue_last,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   depth_lat
);
    localparam logic [AW:0] FULL = {1'b1, {AW{1'b0}}};

    iqpb_state_e   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [RW-1:0] cnt_q;
    logic [RW-1:0] lim_q;
    logic [AW:0]   depth_q;
    logic          wrap;
    logic          at_end;

    always_comb begin
        wrap   = (cnt_q == lim_q);
        at_end = ({1'b0, addr_q} == (depth_q - 1'b1));
    end

    // Next-state logic.
    always_comb begin
        start_acc = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && (cfg_depth != '0)) begin
                    start_acc = 1'b1;
                    state_d   = ST_PLAY;
                end
            end
            ST_PLAY: begin
                if (stop) begin
                    state_d = ST_IDLE;
                end else if (wrap && at_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Address, hold counter and captured configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            lim_q   <= '0;
            depth_q <= '0;
        end else if (start_acc) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            depth_q <= (cfg_depth > FULL) ? FULL : cfg_depth;
            lim_q   <= (cfg_rate <= RW'(1)) ? '0 : (cfg_rate - RW'(1));
        end else if (state_q == ST_PLAY) begin
            if (wrap) begin
                cnt_q <= '0;
                if (!at_end) begin
                    addr_q <= addr_q + 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        issue_vld  = (state_q == ST_PLAY);
        issue_last = issue_vld && wrap && at_end && !stop;
        rd_addr    = addr_q;
        depth_lat  = depth_q;
    end

endmodule

// File: rtl/iqpb_mixer.sv
module iqpb_mixer #(
    parameter int SW = 16,
    parameter int CW = 16,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic                 in_last,
    input  logic signed [SW-1:0] s_i,
    input  logic signed [SW-1:0] s_q,
    input  logic signed [CW-1:0] cos_w,
    input  logic signed [CW-1:0] sin_w,
    output logic signed [OW-1:0] out_w,
    output logic                 out_vld,
    output logic                 out_last
);
    localparam int PW    = SW + CW;
    localparam int DW    = PW + 2;
    localparam int SHIFT = CW - 1;
    localparam logic signed [DW-1:0] RND  = DW'(1) <<< (SHIFT - 1);
    localparam logic signed [DW-1:0] MAXV = DW'((1 <<< (OW - 1)) - 1);
    localparam logic signed [DW-1:0] MINV = -(DW'(1) <<< (OW - 1));

    logic signed [PW-1:0] prod_ic_q, prod_qs_q;
    logic                 vld_a_q, last_a_q;
    logic signed [DW-1:0] diff, scaled;
    logic signed [OW-1:0] clamped;

    // Stage A: two products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_ic_q <= '0;
            prod_qs_q <= '0;
            vld_a_q   <= 1'b0;
            last_a_q  <= 1'b0;
        end else begin
            prod_ic_q <= s_i * cos_w;
            prod_qs_q <= s_q * sin_w;
            vld_a_q   <= in_vld;
            last_a_q  <= in_last;
        end
    end

    always_comb begin
        diff   = DW'(prod_ic_q) - DW'(prod_qs_q);
        scaled = (diff + RND) >>> SHIFT;
        if (scaled > MAXV) begin
            clamped = MAXV[OW-1:0];
        end else if (scaled < MINV) begin
            clamped = MINV[OW-1:0];
        end else begin
            clamped = scaled[OW-1:0];
        end
    end

    // Stage B: registered DAC word, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_w    <= '0;
            out_vld  <= 1'b0;
            out_last <= 1'b0;
        end else begin
            out_w    <= vld_a_q ? clamped : '0;
            out_vld  <= vld_a_q;
            out_last <= last_a_q;
        end
    end

endmodule

// File: rtl/iq_playback_upconv.sv
module iq_playback_upconv #(
    parameter int AW = 8,
    parameter int SW = 16,
    parameter int CW = 16,
    parameter int OW = 16,
    parameter int RW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [SW-1:0] wr_i,
    input  logic [SW-1:0] wr_q,
    input  logic [RW-1:0] cfg_rate,
    input  logic [AW:0]   cfg_depth,
    input  logic          start,
    input  logic          stop,
    input  logic [CW-1:0] nco_cos,
    input  logic [CW-1:0] nco_sin,
    output logic [OW-1:0] dac_out,
    output logic          dac_valid,
    output logic          done
);
    localparam int MW = 2 * SW;

    logic          seq_start_acc;
    logic          seq_issue_vld;
    logic          seq_issue_last;
    logic [AW-1:0] seq_rd_addr;
    logic [AW:0]   seq_depth_lat;
    logic [MW-1:0] ram_rd_data;
    logic          vld1_q, last1_q;
    logic          mix_last;

    iqpb_seq #(.AW(AW), .RW(RW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .cfg_rate   (cfg_rate),
        .cfg_depth  (cfg_depth),
        .start_acc  (seq_start_acc),
        .issue_vld  (seq_issue_vld),
        .issue_last (seq_issue_last),
        .rd_addr    (seq_rd_addr),
        .depth_lat  (seq_depth_lat)
    );

    iqpb_bank_ram #(.AW(AW), .DW(MW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data ({wr_i, wr_q}),
        .snap    (seq_start_acc),
        .rd_addr (seq_rd_addr),
        .rd_data (ram_rd_data)
    );

    // Tag flags aligned with the registered memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld1_q  <= 1'b0;
            last1_q <= 1'b0;
        end else begin
            vld1_q  <= seq_issue_vld;
            last1_q <= seq_issue_last;
        end
    end

    iqpb_mixer #(.SW(SW), .CW(CW), .OW(OW)) u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (vld1_q),
        .in_last  (last1_q),
        .s_i      (ram_rd_data[MW-1:SW]),
        .s_q      (ram_rd_data[SW-1:0]),
        .cos_w    (nco_cos),
        .sin_w    (nco_sin),
        .out_w    (dac_out),
        .out_vld  (dac_valid),
        .out_last (mix_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= mix_last;
        end
    end

endmodule

// File: rtl/iqpb_checker.sv
module iqpb_checker #(
    parameter int AW = 8,
    parameter int OW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_acc,
    input logic          stop,
    input logic          issue_vld,
    input logic [AW-1:0] rd_addr,
    input logic [AW:0]   depth_lat,
    input logic [OW-1:0] dac_out,
    input logic          dac_valid,
    input logic          done
);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dac_valid && (dac_out == '0)));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_valid |-> (dac_out == '0));

    assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> ({1'b0, rd_addr} < depth_lat));

    assert_start_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (issue_vld && (rd_addr == '0)));

    assert_stop_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && stop) |=> !issue_vld);

    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid == $past(issue_vld, 3));

endmodule

bind iq_playback_upconv iqpb_checker #(.AW(AW), .OW(OW)) u_iqpb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (seq_start_acc),
    .stop      (stop),
    .issue_vld (seq_issue_vld),
    .rd_addr   (seq_rd_addr),
    .depth_lat (seq_depth_lat),
    .dac_out   (dac_out),
    .dac_valid (dac_valid),
    .done      (done)
);

// File: tb/iq_playback_upconv_bench.sv
module iq_playback_upconv_bench;
    localparam int AW    = 8;
    localparam int SW    = 16;
    localparam int CW    = 16;
    localparam int OW    = 16;
    localparam int RW    = 12;
    localparam int DEPTH = 1 << AW;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [AW-1:0]        wr_addr = '0;
    logic signed [SW-1:0] wr_i = '0;
    logic signed [SW-1:0] wr_q = '0;
    logic [RW-1:0]        cfg_rate = '0;
    logic [AW:0]          cfg_depth = '0;
    logic                 start = 1'b0;
    logic                 stop = 1'b0;
    logic signed [CW-1:0] nco_cos = '0;
    logic signed [CW-1:0] nco_sin = '0;
    logic signed [OW-1:0] dac_out;
    logic                 dac_valid;
    logic                 done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic signed [SW-1:0] nm_i [DEPTH];
    logic signed [SW-1:0] nm_q [DEPTH];
    logic signed [SW-1:0] pm_i [DEPTH];
    logic signed [SW-1:0] pm_q [DEPTH];
    logic signed [CW-1:0] hist_c [1024];
    logic signed [CW-1:0] hist_s [1024];
    bit                   fix_nco = 1'b0;
    logic signed [CW-1:0] fix_c = '0;
    logic signed [CW-1:0] fix_s = '0;

    always #4 clk = ~clk;

    iq_playback_upconv #(.AW(AW), .SW(SW), .CW(CW), .OW(OW), .RW(RW)) u_iq_playback_upconv (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_i      (wr_i),
        .wr_q      (wr_q),
        .cfg_rate  (cfg_rate),
        .cfg_depth (cfg_depth),
        .start     (start),
        .stop      (stop),
        .nco_cos   (nco_cos),
        .nco_sin   (nco_sin),
        .dac_out   (dac_out),
        .dac_valid (dac_valid),
        .done      (done)
    );

    function automatic longint mix(longint i, longint q, longint c, longint s);
        longint r;
        r = ((i * c - q * s) + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_one(input int addr, input logic signed [SW-1:0] vi,
                             input logic signed [SW-1:0] vq);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_i = vi; wr_q = vq;
        nm_i[addr] = vi; nm_q[addr] = vq;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_pass(input string tag, input int depth, input int rate,
                            input int stop_at, input int wr_at, input bit co_wr);
        int  deff, reff, n, nis, mid, k;
        bit  exp_done;
        longint exp_v;
        logic signed [SW-1:0] vi, vq;
        deff     = (depth > DEPTH) ? DEPTH : depth;
        reff     = (rate <= 1) ? 1 : rate;
        n        = deff * reff;
        nis      = (stop_at > 0) ? stop_at : n;
        exp_done = (stop_at == 0);
        mid      = (nis >= 3) ? 2 : 0;
        @(negedge clk);
        cfg_depth = (AW+1)'(depth);
        cfg_rate  = RW'(rate);
        start     = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            pm_i[a] = nm_i[a]; pm_q[a] = nm_q[a];
        end
        if (co_wr) begin
            // R10: write coincident with an accepted start goes to the next pass
            vi = SW'($urandom); vq = SW'($urandom);
            wr_en = 1'b1; wr_addr = '0; wr_i = vi; wr_q = vq;
            nm_i[0] = vi; nm_q[0] = vq;
        end
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        for (int j = 1; j <= n + 5; j++) begin
            if (fix_nco) begin
                nco_cos = fix_c; nco_sin = fix_s;
            end else begin
                nco_cos = CW'($urandom); nco_sin = CW'($urandom);
            end
            hist_c[j] = nco_cos; hist_s[j] = nco_sin;
            stop  = (j == stop_at);
            start = (j == mid);          // R8: start inside a pass is ignored
            if (j == 3) cfg_rate = cfg_rate + RW'(3);   // R8: config captured at start
            if (j == wr_at) begin
                vi = SW'($urandom); vq = SW'($urandom);
                wr_en = 1'b1; wr_addr = AW'(deff - 1); wr_i = vi; wr_q = vq;
                nm_i[deff-1] = vi; nm_q[deff-1] = vq;
            end else begin
                wr_en = 1'b0;
            end
            if (j >= 4 && (j - 4) < nis) begin
                // R1 R2 R5: step k plays address k/rate with the oscillator of cycle j-2
                k = j - 4;
                exp_v = mix(pm_i[k/reff], pm_q[k/reff], hist_c[j-2], hist_s[j-2]);
                chk(dac_valid == 1'b1, "R5 valid", longint'(dac_valid), 1);
                chk(longint'(dac_out) == exp_v, tag, longint'(dac_out), exp_v);
            end else begin
                chk(!dac_valid && dac_out == '0, "R7 idle output",
                    longint'(dac_out), 0);
            end
            if (exp_done) begin
                chk(done == (j == n + 4), "R6 done", longint'(done), longint'(j == n + 4));
            end else begin
                chk(done == 1'b0, "R9 no done after stop", longint'(done), 0);
            end
            @(negedge clk);
        end
        stop = 1'b0; start = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        int d, r;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(dac_out == '0, "R11 dac_out", longint'(dac_out), 0);
        chk(dac_valid == 1'b0, "R11 dac_valid", longint'(dac_valid), 0);
        chk(done == 1'b0, "R11 done", longint'(done), 0);

        for (int a = 0; a < DEPTH; a++) begin
            write_one(a, SW'($urandom), SW'($urandom));
        end

        run_pass("R1 basic ascending", 8, 1, 0, 0, 1'b0);
        run_pass("R2 rate zero", 5, 0, 0, 0, 1'b0);
        run_pass("R2 rate three", 4, 3, 0, 0, 1'b0);
        run_pass("R3 depth clamp", 300, 1, 0, 0, 1'b0);

        // R3: depth zero start is ignored
        @(negedge clk);
        cfg_depth = '0; cfg_rate = RW'(1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < 8; j++) begin
            chk(!dac_valid && !done, "R3 depth zero ignored",
                longint'({dac_valid, done}), 0);
            @(negedge clk);
        end

        // R4: saturation and rounding corners with a fixed tone
        write_one(0, 16'sd32767, -16'sd32768);
        write_one(1, -16'sd32768, 16'sd32767);
        write_one(2, 16'sd16384, 16'sd0);
        write_one(3, -16'sd1, 16'sd0);
        fix_nco = 1'b1; fix_c = 16'sd32767; fix_s = 16'sd32767;
        run_pass("R4 saturation", 4, 1, 0, 0, 1'b0);
        fix_c = -16'sd32768; fix_s = 16'sd0;
        run_pass("R4 negative full scale", 4, 2, 0, 0, 1'b0);
        fix_nco = 1'b0;

        run_pass("R9 stop mid pass", 20, 2, 7, 0, 1'b0);
        run_pass("R10 write during pass", 10, 2, 0, 3, 1'b0);
        run_pass("R10 next pass sees write", 10, 1, 0, 0, 1'b1);
        run_pass("R10 start-cycle write deferred", 6, 1, 0, 0, 1'b0);

        for (int n = 0; n < 6; n++) begin
            d = 1 + int'($urandom % 40);
            r = int'($urandom % 5);
            run_pass("R4 random mix", d, r, 0, 0, 1'b0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule